// File: doc/BRIEF.md
# Base (-1+j) complex binary adder/subtractor

This block adds or subtracts two complex integers held in a positional binary code whose radix is (-1+j). Digit k of a word weighs (-1+j)^k, and every digit is 0 or 1, so a single bit string carries both the real and the imaginary part. The block is purely combinational. It takes two operands of `OPND_W` digits (a nibble by default) and a subtract select, and returns a `RES_W`-digit word (12 by default) in the same code, together with an overflow flag.

Two doubled digits in one column do not carry into the next column. Instead they clear and set the columns two and three places up. A borrow spreads into a five-digit pattern. Some combinations of pending carries add up to zero and have to vanish rather than keep moving upward. Subtraction is done by adding the subtrahend multiplied by minus one, which in this code is the pattern 11101. The operand width is a parameter, so nibble and byte variants come from the same source.

Top module: `cbx_addsub`

## Requirements
- R1: With `sub_en` = 0, `result` is the unique code of A + B. Here a word's value is the sum over k of bit k times (-1+j)^k, and `ovf` is 0 whenever that code fits in `RES_W` digits.
- R2: With `sub_en` = 1, `result` is the unique code of A - B under the same weighting, and `ovf` is 0 whenever that code fits in `RES_W` digits.
- R3: Adding a one-hot operand to itself clears its column and sets the columns two and three positions higher. For example, 0100 + 0100 gives 000000110000.
- R4: Subtracting a one-hot operand from zero yields the pattern 11101 anchored at that operand's column. For example, 0000 - 0001 gives 000000011101.
- R5: Operands whose values cancel give an all-zero result with `ovf` = 0. This covers 0111 + 0011 and any X - X.
- R6: `ovf` is 1 exactly when the exact code of the result needs a 1 at some digit at or above `RES_W`. `result` always carries the low `RES_W` digits of that exact code.
- R7: Adding a zero operand B returns A zero-extended to `RES_W` digits, with `ovf` = 0.
- R8: With `OPND_W` = 8 and `RES_W` = 24, sums and differences of byte operands are exact and raise no overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | OPND_W | First operand (augend or minuend), radix (-1+j) |
| opnd_b | input | OPND_W | Second operand (addend or subtrahend), radix (-1+j) |
| sub_en | input | 1 | 0 selects A + B, 1 selects A - B |
| result | output | RES_W | Low `RES_W` digits of the exact sum or difference |
| ovf | output | 1 | High when a nonzero digit lies beyond the result width |

## Verification
The bench targets four kinds of case:
- Equal operands. A design that carried into the adjacent column, as plain binary does, would return a left shift by one instead of the two-and-three-up pattern.
- Subtraction from zero and self-subtraction. A mishandled borrow leaves stray digits. A carry chain without cancellation either never settles or reports a false overflow.
- Results that land exactly on the top digit or one digit past it, checked in a narrow six-digit variant. A wrong overflow boundary shows up there as a flag that is off by one position.
- Every operand pair in both modes. Each result is compared, through an independent decoding of the code into real and imaginary parts, with ordinary complex arithmetic.

// File: rtl/cbx_pkg.sv
package cbx_pkg;

    // Column count: at most two operand digits plus three spread borrow digits.
    localparam int CNT_W   = 3;
    // Pending carry components stay within +/-13; seven signed bits leave room.
    localparam int CARRY_W = 7;

    typedef logic [CNT_W-1:0] colcnt_t;

    typedef struct packed {
        logic signed [CARRY_W-1:0] re;
        logic signed [CARRY_W-1:0] im;
    } gauss_t;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } op_e;

    localparam gauss_t GAUSS_ZERO = '0;

    // Span of columns the chain must walk so every operand tap is seen.
    function automatic int col_span(input int opnd_w, input int res_w);
        return (res_w > opnd_w + 4) ? res_w : opnd_w + 4;
    endfunction

    // Parity of a Gaussian integer: the digit it leaves in the current column.
    function automatic logic low_digit(input gauss_t g);
        return g.re[0] ^ g.im[0];
    endfunction

    // Exact division by (-1+j) of a value with even re+im.
    function automatic gauss_t div_by_base(input gauss_t g);
        logic signed [CARRY_W-1:0] r;
        logic signed [CARRY_W-1:0] i;
        logic signed [CARRY_W-1:0] nr;
        logic signed [CARRY_W-1:0] ni;
        gauss_t q;
        r  = g.re;
        i  = g.im;
        nr = i - r;
        ni = -(r + i);
        q.re = nr >>> 1;
        q.im = ni >>> 1;
        return q;
    endfunction

endpackage

// File: rtl/cbx_colgen.sv
module cbx_colgen
    import cbx_pkg::*;
#(
    parameter int OPND_W = 4,
    parameter int NCOL   = 12
) (
    input  logic [OPND_W-1:0]       a_i,
    input  logic [OPND_W-1:0]       b_i,
    input  op_e                     op_i,
    output colcnt_t [NCOL-1:0]      cnt_o
);

    logic neg_en;
    assign neg_en = (op_i == OP_SUB);

    for (genvar k = 0; k < NCOL; k++) begin : g_col
        logic       dir_a;
        logic       dir_b;
        logic [2:0] taps;

        if (k < OPND_W) begin : g_dir
            assign dir_a = a_i[k];
            assign dir_b = b_i[k];
        end else begin : g_dir_none
            assign dir_a = 1'b0;
            assign dir_b = 1'b0;
        end

        // Negation by 11101: subtrahend digit j also lands at j+2, j+3, j+4.
        for (genvar m = 2; m <= 4; m++) begin : g_tap
            if (k - m >= 0 && k - m < OPND_W) begin : g_on
                assign taps[m-2] = neg_en & b_i[k-m];
            end else begin : g_off
                assign taps[m-2] = 1'b0;
            end
        end

        assign cnt_o[k] = CNT_W'(dir_a) + CNT_W'(dir_b) + CNT_W'(taps[0])
                        + CNT_W'(taps[1]) + CNT_W'(taps[2]);
    end

endmodule

// File: rtl/cbx_digit_cell.sv
module cbx_digit_cell
    import cbx_pkg::*;
(
    input  gauss_t  carry_i,
    input  colcnt_t cnt_i,
    output logic    digit_o,
    output gauss_t  carry_o
);

    gauss_t total;
    gauss_t remain;

    always_comb begin
        total.re = carry_i.re + $signed({{(CARRY_W-CNT_W){1'b0}}, cnt_i});
        total.im = carry_i.im;
        digit_o  = low_digit(total);
        remain    = total;
        remain.re = total.re - $signed({{(CARRY_W-1){1'b0}}, digit_o});
        carry_o  = div_by_base(remain);
    end

endmodule

// File: rtl/cbx_normalizer.sv
module cbx_normalizer
    import cbx_pkg::*;
#(
    parameter int NCOL = 12
) (
    input  colcnt_t [NCOL-1:0] cnt_i,
    output logic    [NCOL-1:0] digit_o,
    output gauss_t             carry_o
);

    gauss_t [NCOL:0] chain;

    assign chain[0] = GAUSS_ZERO;

    for (genvar k = 0; k < NCOL; k++) begin : g_cell
        cbx_digit_cell u_cell (
            .carry_i (chain[k]),
            .cnt_i   (cnt_i[k]),
            .digit_o (digit_o[k]),
            .carry_o (chain[k+1])
        );
    end

    assign carry_o = chain[NCOL];

endmodule

// File: rtl/cbx_addsub.sv
module cbx_addsub
    import cbx_pkg::*;
#(
    parameter int OPND_W = 4,
    parameter int RES_W  = 12
) (
    input  logic [OPND_W-1:0] opnd_a,
    input  logic [OPND_W-1:0] opnd_b,
    input  logic              sub_en,
    output logic [RES_W-1:0]  result,
    output logic              ovf
);

    localparam int NCOL = col_span(OPND_W, RES_W);

    op_e                op_sel;
    colcnt_t [NCOL-1:0] col_cnt;
    logic    [NCOL-1:0] digits;
    gauss_t             tail;
    logic               spill;

    assign op_sel = sub_en ? OP_SUB : OP_ADD;

    cbx_colgen #(
        .OPND_W (OPND_W),
        .NCOL   (NCOL)
    ) u_colgen (
        .a_i   (opnd_a),
        .b_i   (opnd_b),
        .op_i  (op_sel),
        .cnt_o (col_cnt)
    );

    cbx_normalizer #(
        .NCOL (NCOL)
    ) u_norm (
        .cnt_i   (col_cnt),
        .digit_o (digits),
        .carry_o (tail)
    );

    assign result = digits[RES_W-1:0];

    if (NCOL > RES_W) begin : g_spill
        assign spill = |digits[NCOL-1:RES_W];
    end else begin : g_no_spill
        assign spill = 1'b0;
    end

    assign ovf = spill | (tail != GAUSS_ZERO);

endmodule

// File: rtl/cbx_addsub_chk.sv
module cbx_addsub_chk #(
    parameter int OPND_W = 4,
    parameter int RES_W  = 12
) (
    input logic [OPND_W-1:0] opnd_a,
    input logic [OPND_W-1:0] opnd_b,
    input logic              sub_en,
    input logic [RES_W-1:0]  result,
    input logic              ovf
);

    logic [RES_W-1:0] a_ext;
    logic [RES_W-1:0] b_ext;

    assign a_ext = RES_W'(opnd_a);
    assign b_ext = RES_W'(opnd_b);

    always_comb begin
        if (!sub_en && opnd_b == '0) begin
            // R7
            identity_chk: assert (result == a_ext && !ovf)
                else $error("identity broken");
        end
        if (sub_en && opnd_a == opnd_b) begin
            // R5
            self_cancel_chk: assert (result == '0 && !ovf)
                else $error("self difference not zero");
        end
        if (!sub_en && opnd_a == OPND_W'(7) && opnd_b == OPND_W'(3)) begin
            // R5
            zero_rule_chk: assert (result == '0 && !ovf)
                else $error("zero rule not applied");
        end
        if (!sub_en && opnd_a == opnd_b && $onehot(opnd_a) && !ovf) begin
            // R3
            carry_rule_chk: assert (result == ((a_ext << 2) | (a_ext << 3)))
                else $error("carry rule broken");
        end
        if (sub_en && opnd_a == '0 && $onehot(opnd_b) && !ovf) begin
            // R4
            borrow_rule_chk: assert (result == (b_ext | (b_ext << 2) | (b_ext << 3) | (b_ext << 4)))
                else $error("borrow rule broken");
        end
    end

endmodule

bind cbx_addsub cbx_addsub_chk #(
    .OPND_W (OPND_W),
    .RES_W  (RES_W)
) u_chk (
    .opnd_a (opnd_a),
    .opnd_b (opnd_b),
    .sub_en (sub_en),
    .result (result),
    .ovf    (ovf)
);

// File: tb/sim_cbx_addsub.sv
module sim_cbx_addsub;

    logic clk = 1'b0;
    logic rst;
    always #10 clk = ~clk;

    logic [3:0]  a4, b4;
    logic        sub4;
    logic [11:0] res0;
    logic        ovf0;
    logic [5:0]  res1;
    logic        ovf1;
    logic [7:0]  a8, b8;
    logic        sub8;
    logic [23:0] res2;
    logic        ovf2;

    cbx_addsub #(.OPND_W(4), .RES_W(12)) u0 (
        .opnd_a(a4), .opnd_b(b4), .sub_en(sub4), .result(res0), .ovf(ovf0));
    cbx_addsub #(.OPND_W(4), .RES_W(6)) u1 (
        .opnd_a(a4), .opnd_b(b4), .sub_en(sub4), .result(res1), .ovf(ovf1));
    cbx_addsub #(.OPND_W(8), .RES_W(24)) u2 (
        .opnd_a(a8), .opnd_b(b8), .sub_en(sub8), .result(res2), .ovf(ovf2));

    int n_chk = 0;
    int n_err = 0;
    int tre[4096];
    int tim[4096];

    function automatic void decode(input logic [23:0] code, input int n,
                                   output int re, output int im);
        int pr = 1;
        int pi = 0;
        int t;
        re = 0;
        im = 0;
        for (int k = 0; k < n; k++) begin
            if (code[k]) begin
                re += pr;
                im += pi;
            end
            t  = -pr - pi;
            pi = pr - pi;
            pr = t;
        end
    endfunction

    function automatic int find_code(input int re, input int im);
        for (int c = 0; c < 4096; c++)
            if (tre[c] == re && tim[c] == im) return c;
        return -1;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive4(input logic [3:0] a, input logic [3:0] b, input logic s);
        @(negedge clk);
        a4 = a; b4 = b; sub4 = s;
        #5;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int ar, ai, br, bi, er, ei, idx, gr, gi;
        a4 = '0; b4 = '0; sub4 = 1'b0;
        a8 = '0; b8 = '0; sub8 = 1'b0;
        rst = 1'b1;
        for (int c = 0; c < 4096; c++) begin
            decode(24'(c), 12, gr, gi);
            tre[c] = gr;
            tim[c] = gi;
        end
        repeat (3) @(posedge clk);
        #5;
        // R7: zero operands give zero result
        check(res0 == '0 && !ovf0, "R7 reset-state zero", {19'd0, ovf0, res0}, 0);
        rst = 1'b0;

        // R1 / R2 / R6: every operand pair in both modes
        for (int s = 0; s < 2; s++) begin
            for (int a = 0; a < 16; a++) begin
                for (int b = 0; b < 16; b++) begin
                    drive4(4'(a), 4'(b), s[0]);
                    decode(24'(a), 4, ar, ai);
                    decode(24'(b), 4, br, bi);
                    er = s ? ar - br : ar + br;
                    ei = s ? ai - bi : ai + bi;
                    idx = find_code(er, ei);
                    if (idx >= 0) begin
                        check(res0 == 12'(idx) && !ovf0, s ? "R2 difference" : "R1 sum",
                              {19'd0, ovf0, res0}, idx);
                        check(res1 == 6'(idx) && ovf1 == (idx >= 64), "R6 narrow overflow",
                              {25'd0, ovf1, res1}, ((idx >= 64) ? 64 : 0) | (idx & 63));
                    end else begin
                        check(ovf0, "R6 wide overflow", ovf0, 1);
                    end
                end
            end
        end

        // R3: doubling a one-hot operand
        drive4(4'b0100, 4'b0100, 1'b0);
        check(res0 == 12'h030 && !ovf0, "R3 carry two and three up", res0, 'h030);
        drive4(4'b0001, 4'b0001, 1'b0);
        check(res0 == 12'h00C && !ovf0, "R3 one plus one", res0, 'h00C);
        // R4: borrow pattern
        drive4(4'b0000, 4'b0001, 1'b1);
        check(res0 == 12'h01D && !ovf0, "R4 zero minus one", res0, 'h01D);
        drive4(4'b0000, 4'b0010, 1'b1);
        check(res0 == 12'h03A && !ovf0, "R4 borrow shifted", res0, 'h03A);
        // R5: cancellation
        drive4(4'b0111, 4'b0011, 1'b0);
        check(res0 == '0 && !ovf0, "R5 zero rule", res0, 0);
        drive4(4'b1011, 4'b1011, 1'b1);
        check(res0 == '0 && !ovf0, "R5 self difference", res0, 0);
        // R7: zero addend
        drive4(4'b1010, 4'b0000, 1'b0);
        check(res0 == 12'h00A && !ovf0, "R7 identity", res0, 'h00A);
        // R6: carry landing one past a six-digit result
        drive4(4'b1000, 4'b1000, 1'b0);
        check(res1 == 6'b100000 && ovf1, "R6 top-digit spill", {25'd0, ovf1, res1}, 'h60);
        drive4(4'b0100, 4'b0100, 1'b0);
        check(res1 == 6'b110000 && !ovf1, "R6 fits at top", {25'd0, ovf1, res1}, 'h30);

        // R8: byte variant, seeded random
        void'($urandom(32'd7341));
        for (int n = 0; n < 300; n++) begin
            @(negedge clk);
            a8 = 8'($urandom);
            b8 = 8'($urandom);
            sub8 = 1'($urandom);
            #5;
            decode(24'(a8), 8, ar, ai);
            decode(24'(b8), 8, br, bi);
            er = sub8 ? ar - br : ar + br;
            ei = sub8 ? ai - bi : ai + bi;
            decode(res2, 24, gr, gi);
            check(gr == er && gi == ei && !ovf2, "R8 byte variant value", gr, er);
        end

        finish_run();
    end

endmodule